// File: doc/BRIEF.md
# Serial Port Pin-Sharing and Ready Controller

This block sits between a four-pin general-purpose port and a serial unit. Each cycle it decides whether each of the four pins belongs to the port or to the serial unit. The four pins carry transmit data, receive data, the shift clock and a transfer-ready line. For a pin the port owns, the port's own direction and data registers pass straight through to the pad. For a pin the serial unit claims, the pad direction and output value come from the serial side. Receive data and an external shift clock are routed back from the pads to the serial unit.

A single 8-bit control register chooses the pin roles. It is loaded through a write strobe. The block also keeps the transfer-ready flag used in clocked (synchronous) mode. The flag drops when software writes the transmit buffer, which tells the link partner that data is waiting. It rises again when the shifter reports that a transfer has begun, or when the ready function is disarmed. The shifter and the baud logic are outside this block. The block only sees a buffer-write strobe and a transfer-started pulse.

Top module: `serial_pin_ctrl`

## Requirements
- R1: After an asynchronous reset (rst_ni low), the control register is zero, all pins are port pins (pin_sel_o = 0) and the ready flag is high. For every pin the port owns, pin_oe_o and pin_out_o equal port_dir_i and port_out_i on that bit.
- R2: Control register layout:
  - bit 7: serial enable
  - bit 6: mode, 1 = UART, 0 = clocked
  - bit 5: receive enable
  - bit 4: transmit enable
  - bit 2: ready-output enable
  - bit 1: clock select, 1 = external
  - bits 3 and 0: no effect
  A write with ctrl_we_i high changes the pin outputs from the next rising edge, and not before.
- R3: Pin 0 (transmit) is claimed only when serial enable and transmit enable are both 1. When claimed, it is an output carrying tx_data_i.
- R4: Pin 1 (receive) is claimed only when serial enable and receive enable are both 1. When claimed, it is an input with pin_out_o[1] = 0, and rx_data_o follows pin_in_i[1]. Otherwise rx_data_o is 1.
- R5: In clocked mode with serial enable set, pin 2 (shift clock) is claimed. With clock select 0 it is an output carrying sclk_out_i. With clock select 1 it is an input with pin_out_o[2] = 0, and sclk_in_o follows pin_in_i[2]. Whenever pin 2 is not a claimed input, sclk_in_o is 0.
- R6: In UART mode with serial enable set, pin 2 is claimed as an external clock input only when clock select is 1. With clock select 0 it stays a port pin.
- R7: Pin 3 (ready) is claimed only when serial enable and ready-output enable are both 1 in clocked mode. When claimed, it is an output carrying the ready flag. It is never claimed in UART mode or without serial enable.
- R8: The ready flag is armed while serial enable, ready-output enable and transmit enable are all 1 and the mode is clocked. While armed, a buf_wr_i pulse clears the flag at the next rising edge, and the flag stays low until released.
- R9: While armed, an xfer_start_i pulse sets the flag high at the next rising edge. If buf_wr_i and xfer_start_i arrive in the same cycle, the buffer write wins and the flag goes low.
- R10: Whenever the ready flag is not armed, it is forced high at the next rising edge, and buf_wr_i has no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_we_i | input | 1 | Control register write strobe |
| ctrl_wdata_i | input | 8 | Control register write data |
| port_dir_i | input | 4 | Port direction register, 1 = output |
| port_out_i | input | 4 | Port data register |
| pin_in_i | input | 4 | Pad input levels |
| tx_data_i | input | 1 | Serial transmit bit from shifter |
| sclk_out_i | input | 1 | Internally generated shift clock |
| buf_wr_i | input | 1 | Transmit buffer write strobe |
| xfer_start_i | input | 1 | Transfer-started pulse from shifter |
| pin_sel_o | output | 4 | Per-pin claim by serial unit (0 tx, 1 rx, 2 clock, 3 ready) |
| pin_oe_o | output | 4 | Per-pin output enable |
| pin_out_o | output | 4 | Per-pin output value |
| rx_data_o | output | 1 | Received bit to shifter |
| sclk_in_o | output | 1 | External shift clock to shifter |

## Verification
Pad routing of data-path inputs (tx_data_i, sclk_out_i, pin_in_i, the port registers) is combinational, so it is due in the same cycle as the stimulus. A control write takes one rising edge to show. So does a buffer write or transfer-start pulse acting on the ready flag, and so does the disarming of the flag. One rising edge after a control change clears an enable, the ready flag still shows its old value; it reads high only after the following edge. The driver applies every stimulus at a falling edge and queues the expected pin state for after the next rising edge. The monitor compares 2 ns after that edge, so each result is checked exactly one edge after its stimulus.

// File: rtl/serial_pin_pkg.sv
package serial_pin_pkg;
  localparam int unsigned CTRL_W   = 8;
  localparam int unsigned NUM_PINS = 4;

  localparam int unsigned PIN_TX  = 0;
  localparam int unsigned PIN_RX  = 1;
  localparam int unsigned PIN_CLK = 2;
  localparam int unsigned PIN_RDY = 3;

  // field order follows bit positions 7..0
  typedef struct packed {
    logic ser_en;
    logic uart;
    logic rx_en;
    logic tx_en;
    logic rsv3;
    logic rdy_en;
    logic clk_ext;
    logic rsv0;
  } ctrl_t;

  localparam logic [CTRL_W-1:0] CTRL_MASK = 8'b1111_0110;
endpackage

// File: rtl/spc_ctrl_reg.sv
module spc_ctrl_reg
  import serial_pin_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [CTRL_W-1:0] wdata_i,
  output ctrl_t             ctrl_o
);
  ctrl_t ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ctrl_q <= '0;
    else if (we_i) ctrl_q <= ctrl_t'(wdata_i & CTRL_MASK);
  end

  assign ctrl_o = ctrl_q;

  p_ctrl_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(ctrl_q));
  p_ctrl_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (ctrl_q.ser_en == $past(wdata_i[7]) && ctrl_q.tx_en == $past(wdata_i[4])
              && ctrl_q.rdy_en == $past(wdata_i[2])));
endmodule

// File: rtl/spc_ready.sv
module spc_ready
  import serial_pin_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  ctrl_t ctrl_i,
  input  logic  buf_wr_i,
  input  logic  xfer_start_i,
  output logic  rdy_o
);
  logic armed;
  logic rdy_q;

  assign armed = ctrl_i.ser_en & ctrl_i.rdy_en & ctrl_i.tx_en & ~ctrl_i.uart;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           rdy_q <= 1'b1;
    else if (!armed)       rdy_q <= 1'b1;
    else if (buf_wr_i)     rdy_q <= 1'b0;
    else if (xfer_start_i) rdy_q <= 1'b1;
  end

  assign rdy_o = rdy_q;

  p_rdy_fall_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && buf_wr_i) |=> !rdy_q);
  p_rdy_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && !rdy_q && !xfer_start_i) |=> !rdy_q);
  p_rdy_start_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && !buf_wr_i && xfer_start_i) |=> rdy_q);
  p_rdy_disarm_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed |=> rdy_q);
endmodule

// File: rtl/spc_pin_route.sv
module spc_pin_route
  import serial_pin_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  ctrl_t               ctrl_i,
  input  logic                rdy_i,
  input  logic                tx_data_i,
  input  logic                sclk_out_i,
  input  logic [NUM_PINS-1:0] port_dir_i,
  input  logic [NUM_PINS-1:0] port_out_i,
  input  logic [NUM_PINS-1:0] pin_in_i,
  output logic [NUM_PINS-1:0] pin_sel_o,
  output logic [NUM_PINS-1:0] pin_oe_o,
  output logic [NUM_PINS-1:0] pin_out_o,
  output logic                rx_data_o,
  output logic                sclk_in_o
);
  logic [NUM_PINS-1:0] claim, ser_oe, ser_out;
  logic unused_pin_in;

  always_comb begin
    claim[PIN_TX]  = ctrl_i.ser_en & ctrl_i.tx_en;
    claim[PIN_RX]  = ctrl_i.ser_en & ctrl_i.rx_en;
    claim[PIN_CLK] = ctrl_i.ser_en & (~ctrl_i.uart | ctrl_i.clk_ext);
    claim[PIN_RDY] = ctrl_i.ser_en & ctrl_i.rdy_en & ~ctrl_i.uart;

    ser_oe[PIN_TX]  = 1'b1;
    ser_oe[PIN_RX]  = 1'b0;
    ser_oe[PIN_CLK] = ~ctrl_i.uart & ~ctrl_i.clk_ext;
    ser_oe[PIN_RDY] = 1'b1;

    ser_out[PIN_TX]  = tx_data_i;
    ser_out[PIN_RX]  = 1'b0;
    ser_out[PIN_CLK] = ser_oe[PIN_CLK] & sclk_out_i;
    ser_out[PIN_RDY] = rdy_i;
  end

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    assign pin_sel_o[i] = claim[i];
    assign pin_oe_o[i]  = claim[i] ? ser_oe[i]  : port_dir_i[i];
    assign pin_out_o[i] = claim[i] ? ser_out[i] : port_out_i[i];

    p_port_pass_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !pin_sel_o[i] |-> (pin_oe_o[i] == port_dir_i[i] && pin_out_o[i] == port_out_i[i]));
  end

  assign rx_data_o = claim[PIN_RX] ? pin_in_i[PIN_RX] : 1'b1;
  assign sclk_in_o = (claim[PIN_CLK] & ~ser_oe[PIN_CLK]) ? pin_in_i[PIN_CLK] : 1'b0;
  assign unused_pin_in = pin_in_i[PIN_TX] ^ pin_in_i[PIN_RDY];

  p_tx_dir_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pin_sel_o[PIN_TX] |-> (pin_oe_o[PIN_TX] && pin_out_o[PIN_TX] == tx_data_i));
  p_rx_dir_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pin_sel_o[PIN_RX] |-> !pin_oe_o[PIN_RX]);
  p_clk_uart_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_i.uart && pin_sel_o[PIN_CLK]) |-> !pin_oe_o[PIN_CLK]);
  p_rdy_uart_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_i.uart |-> !pin_sel_o[PIN_RDY]);
  p_clk_in_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pin_oe_o[PIN_CLK] |-> !sclk_in_o);
endmodule

// File: rtl/serial_pin_ctrl.sv
module serial_pin_ctrl
  import serial_pin_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                ctrl_we_i,
  input  logic [CTRL_W-1:0]   ctrl_wdata_i,
  input  logic [NUM_PINS-1:0] port_dir_i,
  input  logic [NUM_PINS-1:0] port_out_i,
  input  logic [NUM_PINS-1:0] pin_in_i,
  input  logic                tx_data_i,
  input  logic                sclk_out_i,
  input  logic                buf_wr_i,
  input  logic                xfer_start_i,
  output logic [NUM_PINS-1:0] pin_sel_o,
  output logic [NUM_PINS-1:0] pin_oe_o,
  output logic [NUM_PINS-1:0] pin_out_o,
  output logic                rx_data_o,
  output logic                sclk_in_o
);
  ctrl_t ctrl;
  logic  rdy;

  spc_ctrl_reg u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (ctrl_we_i),
    .wdata_i (ctrl_wdata_i),
    .ctrl_o  (ctrl)
  );

  spc_ready u_ready (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .ctrl_i       (ctrl),
    .buf_wr_i     (buf_wr_i),
    .xfer_start_i (xfer_start_i),
    .rdy_o        (rdy)
  );

  spc_pin_route u_route (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ctrl_i     (ctrl),
    .rdy_i      (rdy),
    .tx_data_i  (tx_data_i),
    .sclk_out_i (sclk_out_i),
    .port_dir_i (port_dir_i),
    .port_out_i (port_out_i),
    .pin_in_i   (pin_in_i),
    .pin_sel_o  (pin_sel_o),
    .pin_oe_o   (pin_oe_o),
    .pin_out_o  (pin_out_o),
    .rx_data_o  (rx_data_o),
    .sclk_in_o  (sclk_in_o)
  );
endmodule

// File: tb/tb_serial_pin_ctrl.sv
module tb_serial_pin_ctrl;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       ctrl_we_i = 1'b0;
  logic [7:0] ctrl_wdata_i = '0;
  logic [3:0] port_dir_i = '0, port_out_i = '0, pin_in_i = '0;
  logic       tx_data_i = 1'b0, sclk_out_i = 1'b0, buf_wr_i = 1'b0, xfer_start_i = 1'b0;
  logic [3:0] pin_sel_o, pin_oe_o, pin_out_o;
  logic       rx_data_o, sclk_in_o;

  serial_pin_ctrl dut (.*);

  always #4 clk_i = ~clk_i;

  typedef struct {
    logic [13:0] val;
    string       tag;
  } exp_t;

  exp_t q[$];
  int   n_vec = 0, n_bad = 0;
  bit   done = 0;

  // model state, from the requirements
  logic [7:0] m_ctrl = '0;
  logic       m_rdy  = 1'b1;
  logic [3:0] nxt_pd = 4'b1010, nxt_po = 4'b0110;
  logic       nxt_rst = 1'b0;

  function automatic logic [13:0] expect_pins(logic [7:0] c, logic rdy, logic [3:0] pd,
                                              logic [3:0] po, logic [3:0] pi, logic txd,
                                              logic sco);
    logic sen, uart, ren, ten, ren_rdy, cs;
    logic [3:0] s, oe, o;
    logic rx, sci;
    sen = c[7]; uart = c[6]; ren = c[5]; ten = c[4]; ren_rdy = c[2]; cs = c[1];
    s[0] = sen & ten;
    s[1] = sen & ren;
    s[2] = sen & (!uart | cs);
    s[3] = sen & ren_rdy & !uart;
    oe[0] = s[0] ? 1'b1 : pd[0];             o[0] = s[0] ? txd : po[0];
    oe[1] = s[1] ? 1'b0 : pd[1];             o[1] = s[1] ? 1'b0 : po[1];
    oe[2] = s[2] ? (!uart & !cs) : pd[2];    o[2] = s[2] ? ((!uart & !cs) ? sco : 1'b0) : po[2];
    oe[3] = s[3] ? 1'b1 : pd[3];             o[3] = s[3] ? rdy : po[3];
    rx  = s[1] ? pi[1] : 1'b1;
    sci = (s[2] && uart | cs && s[2]) ? pi[2] : 1'b0;
    return {s, oe, o, rx, sci};
  endfunction

  task automatic step(input logic we, input logic [7:0] wd, input logic bw, input logic xs,
                      input logic [3:0] pi, input logic txd, input logic sco, input string tag);
    logic arm;
    exp_t e;
    @(negedge clk_i);
    rst_ni = nxt_rst; ctrl_we_i = we; ctrl_wdata_i = wd; buf_wr_i = bw; xfer_start_i = xs;
    pin_in_i = pi; tx_data_i = txd; sclk_out_i = sco; port_dir_i = nxt_pd; port_out_i = nxt_po;
    if (!nxt_rst) begin
      m_ctrl = '0; m_rdy = 1'b1;
    end else begin
      arm = m_ctrl[7] & m_ctrl[2] & m_ctrl[4] & !m_ctrl[6];
      if (!arm)    m_rdy = 1'b1;
      else if (bw) m_rdy = 1'b0;
      else if (xs) m_rdy = 1'b1;
      if (we) m_ctrl = wd;
    end
    e.val = expect_pins(m_ctrl, m_rdy, nxt_pd, nxt_po, pi, txd, sco);
    e.tag = tag;
    q.push_back(e);
  endtask

  // monitor: compare 2 ns after every rising edge
  initial begin
    forever begin
      @(posedge clk_i);
      #2;
      if (q.size() > 0) begin
        exp_t e;
        logic [13:0] act;
        e = q.pop_front();
        act = {pin_sel_o, pin_oe_o, pin_out_o, rx_data_o, sclk_in_o};
        n_vec++;
        if (act !== e.val) begin
          n_bad++;
          $display("FAIL %s: sel/oe/out/rx/sclk actual %h expected %h", e.tag, act, e.val);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    // R1 reset state, two port patterns
    step(0, 8'h00, 0, 0, 4'hF, 1, 1, "R1 reset");
    nxt_pd = 4'b0101; nxt_po = 4'b1001;
    step(0, 8'h00, 0, 0, 4'h0, 0, 0, "R1 reset pattern2");
    nxt_rst = 1'b1;
    step(0, 8'h00, 0, 0, 4'h0, 1, 0, "R1 idle");
    // R3 transmit pin
    step(1, 8'h10, 0, 0, 4'h0, 1, 0, "R3 tx_en without ser_en");
    step(1, 8'h90, 0, 0, 4'h0, 1, 1, "R3 tx claimed");
    step(0, 8'h00, 0, 0, 4'h0, 0, 0, "R3 tx follows data");
    step(0, 8'h00, 0, 0, 4'h0, 0, 1, "R5 internal clock out");
    // R4 receive pin
    step(1, 8'hA0, 0, 0, 4'h2, 0, 0, "R4 rx claimed high");
    step(0, 8'h00, 0, 0, 4'h0, 0, 0, "R4 rx claimed low");
    // R5 clocked external clock
    step(1, 8'h82, 0, 0, 4'h4, 0, 1, "R5 external clock high");
    step(0, 8'h00, 0, 0, 4'h0, 0, 1, "R5 external clock low");
    // R6 UART clock pin
    step(1, 8'hC2, 0, 0, 4'h4, 0, 1, "R6 uart external clock");
    step(1, 8'hC0, 0, 0, 4'h4, 0, 1, "R6 uart clock pin to port");
    // R7 ready in UART / no enable
    step(1, 8'hD4, 1, 0, 4'h0, 0, 0, "R7 uart ready not claimed");
    step(0, 8'h00, 0, 0, 4'h0, 0, 0, "R7 uart after buffer write");
    step(1, 8'h14, 1, 0, 4'h0, 0, 0, "R7 no ser_en");
    // R8/R9 handshake
    step(1, 8'h94, 0, 0, 4'h0, 0, 0, "R7 ready claimed high");
    step(0, 8'h00, 1, 0, 4'h0, 0, 0, "R8 buffer write lowers ready");
    step(0, 8'h00, 0, 0, 4'h0, 0, 0, "R8 ready stays low");
    step(0, 8'h00, 0, 1, 4'h0, 0, 0, "R9 start raises ready");
    step(0, 8'h00, 1, 1, 4'h0, 0, 0, "R9 write wins over start");
    // R2 reserved bits ignored, write timing
    step(1, 8'h9D, 0, 0, 4'h0, 0, 0, "R2 reserved bits no effect");
    // R10 disarm
    step(1, 8'h84, 0, 0, 4'h0, 0, 0, "R10 tx_en cleared, flag not yet");
    step(0, 8'h00, 0, 0, 4'h0, 0, 0, "R10 ready forced high");
    step(0, 8'h00, 1, 0, 4'h0, 0, 0, "R10 buffer write ignored");
    step(0, 8'h00, 0, 0, 4'h0, 0, 0, "R10 still high");
    // R2 write changes pins only after the edge, then reset mid-run
    step(1, 8'hB0, 0, 0, 4'h2, 1, 0, "R2 new control visible");
    nxt_rst = 1'b0;
    step(0, 8'h00, 0, 0, 4'h2, 1, 0, "R1 reset mid-run");
    nxt_rst = 1'b1;
    step(0, 8'h00, 0, 0, 4'h0, 0, 0, "R1 after reset");
    repeat (3) @(posedge clk_i);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule